// File: doc/BRIEF.md
# Write-Enable and Block-Protect Status Unit

This unit sits between the serial command front end of a small serial EEPROM and its array write path. It owns the write-enable latch and the two block-protect bits. It assembles the 8-bit status byte that the front end shifts out when the host asks for status. It also answers, for any candidate array address, whether a write to that address may go ahead.

The front end reports decoded events as one-cycle strobes on the unit's clock:
- set-enable;
- clear-enable;
- array write start;
- end of a status-write frame, together with the number of data bits clocked in after the instruction byte.

A separate programming timer drives the write-in-progress flag. A new protect setting is sent to the non-volatile cell as a one-cycle request. The cell's stored value comes back in on `bp_stored` and is loaded at reset. Until the programming cycle ends, status reads return the old protect bits.

Top module: `eewp_status_unit`

## Requirements
- R1: `status_byte` bits 7..4 are always 1; bit 3 is protect bit 1; bit 2 is protect bit 0; bit 1 is the write-enable latch; bit 0 follows `busy_in` in the same cycle.
- R2: A `set_en` strobe sampled while `wp_n` is high sets the enable latch at that clock edge. While `wp_n` is low, `set_en` has no effect.
- R3: A `clr_en` strobe clears the enable latch at that edge. When `clr_en` and `set_en` arrive together, the clear takes priority.
- R4: An executed status write (R6) or an `arr_start` strobe clears the enable latch at that edge.
- R5: While `wp_n` is low, `write_permit` is 0 in the same cycle. At every clock edge where `wp_n` is sampled low, the enable latch is cleared.
- R6: A `sr_end` strobe executes a status write only when `sr_bitcnt` equals 8. When the status write commits (see R7), `bp_prog_req` pulses high for one cycle, starting at the next edge. `bp_prog_val` then carries data bits 3..2 of `sr_data`. Any other bit count leaves the enable latch and the protect bits unchanged and raises no request.
- R7: The protect bits change only if the enable latch is 1 and `wp_n` is high at the edge where the status write executes. Otherwise no request is raised and the protect bits stay as they are.
- R8: After a commit, status reads keep showing the old protect bits until `busy_in` has been seen high and then low. Lowering `wp_n` in the meantime does not cancel the pending update.
- R9: The protect bits select the locked address range of the 512-byte array. 00 locks nothing. 01 locks 180h-1FFh. 10 locks 100h-1FFh. 11 locks 000h-1FFh.
- R10: `write_permit` is 1 exactly when three conditions hold: the enable latch is 1, `wp_n` is high, and `chk_addr` lies outside the locked range.
- R11: While `rst_n` is sampled low, the enable latch is cleared and the protect bits are loaded from `bp_stored`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wp_n | input | 1 | Hardware write-protect pin; low blocks writes |
| set_en | input | 1 | Set-enable command strobe |
| clr_en | input | 1 | Clear-enable command strobe |
| sr_end | input | 1 | Select released during a status-write command |
| sr_bitcnt | input | 5 | Data bits received after the instruction byte (saturating) |
| sr_data | input | 8 | Status byte received from the host |
| arr_start | input | 1 | Array programming cycle has begun |
| busy_in | input | 1 | Programming cycle in progress |
| bp_stored | input | 2 | Protect bits held in the non-volatile cell |
| chk_addr | input | 9 | Candidate array write address |
| status_byte | output | 8 | Status byte for the read-status command |
| write_permit | output | 1 | Write to `chk_addr` may proceed |
| bp_prog_req | output | 1 | One-cycle request to program new protect bits |
| bp_prog_val | output | 2 | Protect value to program |

## Verification
On every cycle, the assertions check how the latch reacts to each of its strobes and to the write-protect pin. They also check that a request is never raised unless a status write executes with the latch set and `wp_n` high, and that the protect bits hold still while an update waits behind `busy_in`. The address map, the exact bit layout of the status byte, and the point at which the delayed protect bits become visible need whole command sequences to show. The bench's scenarios cover these, including a `wp_n` drop in the middle of a cycle and a reset that reloads stored protect bits.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
  localparam int SR_FRAME_BITS = 8;
  localparam int BP_FIELD_LSB  = 2;

  // Locked-region test: top two address bits against the protect code.
  function automatic logic addr_locked(input logic [1:0] addr_top, input logic [1:0] bp);
    logic r;
    case (bp)
      2'b00:   r = 1'b0;
      2'b01:   r = (addr_top == 2'b11);
      2'b10:   r = addr_top[1];
      default: r = 1'b1;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] pack_status(input logic [1:0] bp, input logic wel,
                                             input logic wip);
    return {4'hF, bp, wel, wip};
  endfunction
endpackage

// File: rtl/eewp_wel_latch.sv
module eewp_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n,
  input  logic set_req,
  input  logic clr_req,
  output logic wel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        wel_q <= 1'b0;
    else if (!wp_n)    wel_q <= 1'b0;
    else if (clr_req)  wel_q <= 1'b0;
    else if (set_req)  wel_q <= 1'b1;
  end

  assert_wp_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> !wel_q);
  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !wel_q);
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !clr_req && wp_n) |=> wel_q);
endmodule

// File: rtl/eewp_bp_store.sv
module eewp_bp_store (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bp_init,
  input  logic       commit,
  input  logic [1:0] commit_val,
  input  logic       busy_in,
  output logic [1:0] bp_q,
  output logic       pend_q,
  output logic       prog_req,
  output logic [1:0] prog_val
);
  logic       busy_d;
  logic       busy_fall;
  logic [1:0] pend_val;

  assign busy_fall = busy_d && !busy_in;
  assign prog_val  = pend_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_q     <= bp_init;
      pend_q   <= 1'b0;
      pend_val <= 2'b00;
      busy_d   <= 1'b0;
      prog_req <= 1'b0;
    end else begin
      busy_d   <= busy_in;
      prog_req <= commit;
      if (commit) begin
        pend_q   <= 1'b1;
        pend_val <= commit_val;
      end else if (pend_q && busy_fall) begin
        pend_q <= 1'b0;
        bp_q   <= pend_val;
      end
    end
  end

  // R8: while the cycle runs, the visible bits hold and the update stays queued
  assert_old_bp_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && busy_in) |=> ($stable(bp_q) && pend_q));
  assert_no_change_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !commit) |=> $stable(bp_q));
endmodule

// File: rtl/eewp_status_unit.sv
module eewp_status_unit #(
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic              sr_end,
  input  logic [CNT_W-1:0]  sr_bitcnt,
  input  logic [7:0]        sr_data,
  input  logic              arr_start,
  input  logic              busy_in,
  input  logic [1:0]        bp_stored,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [7:0]        status_byte,
  output logic              write_permit,
  output logic              bp_prog_req,
  output logic [1:0]        bp_prog_val
);
  import eewp_pkg::*;

  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(SR_FRAME_BITS);

  logic       wel_q;
  logic       sr_exec;
  logic       sr_accept;
  logic       wel_clear;
  logic [1:0] bp_q;
  logic       bp_pend;
  logic       addr_hit;

  assign sr_exec   = sr_end && (sr_bitcnt == FRAME_CNT);
  assign sr_accept = sr_exec && wel_q && wp_n;
  assign wel_clear = clr_en || sr_exec || arr_start;

  eewp_wel_latch u_wel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wp_n    (wp_n),
    .set_req (set_en),
    .clr_req (wel_clear),
    .wel_q   (wel_q)
  );

  eewp_bp_store u_bp (
    .clk        (clk),
    .rst_n      (rst_n),
    .bp_init    (bp_stored),
    .commit     (sr_accept),
    .commit_val (sr_data[BP_FIELD_LSB +: 2]),
    .busy_in    (busy_in),
    .bp_q       (bp_q),
    .pend_q     (bp_pend),
    .prog_req   (bp_prog_req),
    .prog_val   (bp_prog_val)
  );

  assign addr_hit     = addr_locked(chk_addr[ADDR_W-1 -: 2], bp_q);
  assign write_permit = wel_q && wp_n && !addr_hit;
  assign status_byte  = pack_status(bp_q, wel_q, busy_in);

  assert_req_needs_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bp_prog_req) |-> ($past(wel_q) && $past(wp_n)));
  assert_bad_count_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_end && sr_bitcnt != FRAME_CNT) |=> !bp_prog_req);
  assert_exec_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_exec || arr_start) |=> !status_byte[1]);
  assert_permit_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    write_permit |-> (wp_n && status_byte[1]));
  assert_wip_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[0] == busy_in);
endmodule

// File: tb/eewp_status_unit_tb.sv
module eewp_status_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1, set_en = 1'b0, clr_en = 1'b0, sr_end = 1'b0, arr_start = 1'b0;
  logic busy_in = 1'b0;
  logic [4:0] sr_bitcnt = '0;
  logic [7:0] sr_data = '0;
  logic [1:0] bp_stored = 2'b00;
  logic [8:0] chk_addr = '0;
  logic [7:0] status_byte;
  logic write_permit, bp_prog_req;
  logic [1:0] bp_prog_val;

  always #5 clk = ~clk;

  eewp_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .set_en(set_en), .clr_en(clr_en),
    .sr_end(sr_end), .sr_bitcnt(sr_bitcnt), .sr_data(sr_data), .arr_start(arr_start),
    .busy_in(busy_in), .bp_stored(bp_stored), .chk_addr(chk_addr),
    .status_byte(status_byte), .write_permit(write_permit),
    .bp_prog_req(bp_prog_req), .bp_prog_val(bp_prog_val)
  );

  typedef struct {
    string      tag;
    logic [7:0] st;
    logic       pm;
    logic       pr;
  } item_t;

  item_t exp_q[$];
  event  mon_ev;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic logic [7:0] sv(input logic [1:0] bp, input logic wel, input logic wip);
    logic [7:0] v;
    v = 8'hF0;
    v[3] = bp[1]; v[2] = bp[0]; v[1] = wel; v[0] = wip;
    return v;
  endfunction

  function automatic logic locked(input int addr, input logic [1:0] bp);
    if (bp == 2'd1) return addr >= 384;
    if (bp == 2'd2) return addr >= 256;
    if (bp == 2'd3) return 1'b1;
    return 1'b0;
  endfunction

  always begin
    @(mon_ev);
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if (status_byte !== it.st || write_permit !== it.pm || bp_prog_req !== it.pr) begin
        errors++;
        $display("FAIL %s: status %h permit %b req %b, expected status %h permit %b req %b",
                 it.tag, status_byte, write_permit, bp_prog_req, it.st, it.pm, it.pr);
      end
    end
  end

  task automatic expect_it(input string tag, input logic [7:0] st, input logic pm, input logic pr);
    item_t it;
    it.tag = tag; it.st = st; it.pm = pm; it.pr = pr;
    exp_q.push_back(it);
    ->mon_ev;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    set_en = 0; clr_en = 0; sr_end = 0; arr_start = 0;
  endtask

  task automatic wrsr(input logic [4:0] cnt, input logic [7:0] d);
    sr_end = 1; sr_bitcnt = cnt; sr_data = d;
    tick();
  endtask

  // program cycle: busy rises then falls
  task automatic busy_pulse();
    busy_in = 1; tick();
    busy_in = 0; tick();
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    chk_addr = 9'h000;
    expect_it("R11 R1 reset state", sv(2'b00, 0, 0), 0, 0);

    set_en = 1; tick();
    chk_addr = 9'h1FF;
    expect_it("R2 set enable", sv(2'b00, 1, 0), !locked(511, 2'b00), 0);

    clr_en = 1; tick();
    expect_it("R3 clear enable", sv(2'b00, 0, 0), 0, 0);

    set_en = 1; clr_en = 1; tick();
    expect_it("R3 clear beats set", sv(2'b00, 0, 0), 0, 0);

    set_en = 1; tick();
    wp_n = 0; #1;
    expect_it("R5 permit drops at once", sv(2'b00, 1, 0), 0, 0);
    tick();
    expect_it("R5 latch cleared by W", sv(2'b00, 0, 0), 0, 0);
    set_en = 1; tick();
    expect_it("R2 set ignored under W low", sv(2'b00, 0, 0), 0, 0);
    wp_n = 1;

    set_en = 1; tick();
    wrsr(5'd9, 8'h0C);
    expect_it("R6 nine bits: no commit", sv(2'b00, 1, 0), 1, 0);
    wrsr(5'd8, 8'h08);
    expect_it("R6 eight bits commit", sv(2'b00, 0, 0), 0, 1);
    if (bp_prog_val !== 2'b10) begin
      errors++;
      $display("FAIL R6: prog value %b, expected 10", bp_prog_val);
    end
    checks++;
    busy_in = 1; tick();
    expect_it("R8 old bits during busy", sv(2'b00, 0, 1), 0, 0);
    wp_n = 0; tick();
    wp_n = 1;
    expect_it("R8 W low does not cancel", sv(2'b00, 0, 1), 0, 0);
    busy_in = 0; tick();
    expect_it("R8 new bits after busy", sv(2'b10, 0, 0), 0, 0);

    set_en = 1; tick();
    chk_addr = 9'h0FF; #1;
    expect_it("R9 R10 bp10 below 100h", sv(2'b10, 1, 0), !locked(255, 2'b10), 0);
    chk_addr = 9'h100; #1;
    expect_it("R9 bp10 at 100h", sv(2'b10, 1, 0), !locked(256, 2'b10), 0);

    clr_en = 1; tick();
    wrsr(5'd8, 8'h0C);
    expect_it("R7 no WEL no commit", sv(2'b10, 0, 0), 0, 0);
    busy_pulse();
    expect_it("R7 bits unchanged", sv(2'b10, 0, 0), 0, 0);

    set_en = 1; tick();
    wp_n = 0;
    wrsr(5'd8, 8'h0C);
    wp_n = 1;
    busy_pulse();
    expect_it("R7 W low at commit", sv(2'b10, 0, 0), 0, 0);

    set_en = 1; tick();
    wrsr(5'd8, 8'h04);
    busy_pulse();
    set_en = 1; tick();
    chk_addr = 9'h17F; #1;
    expect_it("R9 bp01 below 180h", sv(2'b01, 1, 0), !locked(383, 2'b01), 0);
    chk_addr = 9'h180; #1;
    expect_it("R9 bp01 at 180h", sv(2'b01, 1, 0), !locked(384, 2'b01), 0);

    arr_start = 1; tick();
    expect_it("R4 array start clears", sv(2'b01, 0, 0), 0, 0);

    set_en = 1; tick();
    wrsr(5'd8, 8'hFF);
    busy_pulse();
    set_en = 1; tick();
    chk_addr = 9'h000; #1;
    expect_it("R9 bp11 locks all", sv(2'b11, 1, 0), !locked(0, 2'b11), 0);

    bp_stored = 2'b01; rst_n = 0; tick(); rst_n = 1;
    expect_it("R11 reload stored bits", sv(2'b01, 0, 0), 0, 0);

    finished = 1;
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule